// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer with Clock Suspend

This block is the device-side column engine of a synchronous DRAM model. It receives commands that are already decoded (no-op, read, write), each with a bank and a start column. From these it produces one column access per internal clock edge. Writes store the write-data input into a small internal array. Reads send the array word through a CAS-latency pipeline to the read-data output.

The mode inputs select the burst length, the burst order (sequential or interleaved), the CAS latency, and a write-single setting. With write-single set, every write becomes a burst of one, while reads keep the programmed length. A new read or write that arrives during a burst cuts that burst short.

A clock-enable input gates the internal clock. A low sample suppresses the following internal edge. On that edge the command, the write data, the beat counter and the read pipeline are all frozen, so the burst resumes exactly where it stopped.

Top module: `sdram_burst_seq`

## Requirements
- R1: Command code 1 is READ, 2 is WRITE, and 0 or 3 is a no-op. A READ or WRITE makes its first column access on the internal edge where it is taken. Each later beat takes one further internal edge. During an access edge `accActive` is high and `accCol` shows the column being addressed.
- R2: If `clkEn` is low at a rising edge, the next rising edge is suppressed. On the suppressed edge `accActive` is low, and the command and write data present at that edge are ignored.
- R3: While an edge is suppressed, `rdData` and `rdValid` keep their values.
- R4: The beat counter does not advance on a suppressed edge. The burst continues from the same beat on the next edge that is not suppressed.
- R5: When `writeSingle` is 1, a WRITE accesses only its start column. Reads still run for the programmed length.
- R6: `lenCode` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. Every address stays inside the block of that size that is aligned on the start column.
- R7: When `interleave` is 0, the low column bits are (start + beat) modulo the length. When it is 1, they are start XOR beat.
- R8: With `casLat` = c (1 to 3; 0 acts as 1), the first word of a read is valid on the output after the (c-1)th internal edge following the command edge. Later words follow on consecutive internal edges.
- R9: A READ or WRITE taken during an active burst ends the old burst. The new burst starts on that same edge, and the old burst's remaining beats never appear.
- R10: After reset `rdValid` and `accActive` are low and the internal clock is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Clock enable; a low sample suppresses the next edge |
| cmd | input | 2 | Decoded command: 0 no-op, 1 READ, 2 WRITE |
| bank | input | BANK_W | Bank of the command |
| col | input | COL_W | Start column of the command |
| lenCode | input | 2 | Burst length code (1 << lenCode beats) |
| interleave | input | 1 | 0 sequential, 1 interleaved order |
| casLat | input | 2 | CAS latency in internal cycles |
| writeSingle | input | 1 | 1 forces writes to one beat |
| wrData | input | DATA_W | Write data for the current beat |
| accActive | output | 1 | A column access happens on this edge |
| accCol | output | COL_W | Column addressed on this edge |
| rdData | output | DATA_W | Read data |
| rdValid | output | 1 | Read data valid |

## Verification
The hardest case is a suppressed edge that lands in the middle of a burst. In that case the command and write data offered at that edge must be dropped. It is reached by lowering `clkEn` exactly one edge after a burst starts. A conflicting WRITE and a marker data word are then driven during the suppressed edge. Reading those columns back afterwards shows that nothing landed there. A read burst is frozen the same way, and the output word is checked to stay put. Truncation is exercised by issuing a second read while the first is still in flight. The bench then checks that the output stream switches to the new bank with no stale beats in between.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_RSVD  = 2'd3
  } seqCmd_e;

  // Strobes from control to datapath for the current edge
  typedef struct packed {
    logic tick;     // internal edge not suppressed
    logic load;     // new command taken, beat 0
    logic access;   // a column access happens
    logic isWrite;  // the access is a write
  } ctlStrobe_t;

endpackage

// File: rtl/sdram_seq_ctl.sv
module sdram_seq_ctl
  import sdram_seq_pkg::*;
#(
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [1:0]        cmd,
  input  logic [1:0]        lenCode,
  input  logic              writeSingle,
  output ctlStrobe_t        strobe,
  output logic [BEAT_W-1:0] beatCur
);

  localparam int LEN_W = BEAT_W + 1;

  logic              clkEnQ;
  logic              activeR;
  logic              wrR;
  logic [BEAT_W-1:0] beatR;
  logic [LEN_W-1:0]  lenR;

  logic             isCmd;
  logic             cmdWrite;
  logic [LEN_W-1:0] lenProg;
  logic [LEN_W-1:0] lenUse;
  logic [LEN_W-1:0] beatNext;

  always_comb begin
    cmdWrite = (cmd == CMD_WRITE);
    isCmd    = clkEnQ && ((cmd == CMD_READ) || cmdWrite);
    lenProg  = {{BEAT_W{1'b0}}, 1'b1} << lenCode;
    lenUse   = (cmdWrite && writeSingle) ? {{BEAT_W{1'b0}}, 1'b1} : lenProg;
    beatNext = {1'b0, beatR} + {{BEAT_W{1'b0}}, 1'b1};

    strobe.tick    = clkEnQ;
    strobe.load    = isCmd;
    strobe.access  = isCmd || (clkEnQ && activeR);
    strobe.isWrite = isCmd ? cmdWrite : wrR;
    beatCur        = isCmd ? '0 : beatR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkEnQ  <= 1'b1;
      activeR <= 1'b0;
      wrR     <= 1'b0;
      beatR   <= '0;
      lenR    <= {{BEAT_W{1'b0}}, 1'b1};
    end else begin
      clkEnQ <= clkEn;
      if (isCmd) begin
        beatR   <= {{(BEAT_W-1){1'b0}}, 1'b1};
        lenR    <= lenUse;
        wrR     <= cmdWrite;
        activeR <= (lenUse > {{BEAT_W{1'b0}}, 1'b1});
      end else if (clkEnQ && activeR) begin
        beatR <= beatNext[BEAT_W-1:0];
        if (beatNext == lenR) activeR <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8,
  parameter int BEAT_W = 3,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [BEAT_W-1:0] beatCur,
  input  logic [BANK_W-1:0] bankIn,
  input  logic [COL_W-1:0]  colIn,
  input  logic [1:0]        lenCode,
  input  logic              interleave,
  input  logic [1:0]        casLat,
  input  logic [DATA_W-1:0] wrData,
  output logic [COL_W-1:0]  accCol,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int ADDR_W = BANK_W + COL_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SEL_W  = (MAX_CL > 1) ? $clog2(MAX_CL) : 1;

  logic [BANK_W-1:0] bankR;
  logic [COL_W-1:0]  startR;
  logic [COL_W-1:0]  maskR;
  logic              ilvR;

  logic [COL_W-1:0]  maskNew;
  logic [BANK_W-1:0] curBank;
  logic [COL_W-1:0]  curStart;
  logic [COL_W-1:0]  curMask;
  logic              curIlv;
  logic [COL_W-1:0]  beatExt;
  logic [COL_W-1:0]  lowBits;
  logic [ADDR_W-1:0] addr;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [MAX_CL-1:0] pipeV;
  logic [DATA_W-1:0] pipeD [MAX_CL];
  logic [SEL_W-1:0]  selIdx;

  // address generation
  always_comb begin
    maskNew = '0;
    for (int i = 0; i < COL_W; i++) begin
      if (i < int'(lenCode)) maskNew[i] = 1'b1;
    end
    curBank  = strobe.load ? bankIn     : bankR;
    curStart = strobe.load ? colIn      : startR;
    curMask  = strobe.load ? maskNew    : maskR;
    curIlv   = strobe.load ? interleave : ilvR;
    beatExt  = COL_W'(beatCur);
    lowBits  = curIlv ? (curStart ^ beatExt) : (curStart + beatExt);
    accCol   = (curStart & ~curMask) | (lowBits & curMask);
    addr     = {curBank, accCol};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankR  <= '0;
      startR <= '0;
      maskR  <= '0;
      ilvR   <= 1'b0;
    end else if (strobe.load) begin
      bankR  <= bankIn;
      startR <= colIn;
      maskR  <= maskNew;
      ilvR   <= interleave;
    end
  end

  // storage array
  always_ff @(posedge clk) begin
    if (strobe.access && strobe.isWrite) mem[addr] <= wrData;
  end

  // latency pipeline, frozen on suppressed edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeV[0] <= 1'b0;
      pipeD[0] <= '0;
    end else if (strobe.tick) begin
      pipeV[0] <= strobe.access && !strobe.isWrite;
      pipeD[0] <= mem[addr];
    end
  end

  for (genvar g = 1; g < MAX_CL; g++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pipeV[g] <= 1'b0;
        pipeD[g] <= '0;
      end else if (strobe.tick) begin
        pipeV[g] <= pipeV[g-1];
        pipeD[g] <= pipeD[g-1];
      end
    end
  end

  always_comb begin
    if (casLat == 2'd0) selIdx = '0;
    else if (int'(casLat) > MAX_CL) selIdx = SEL_W'(MAX_CL - 1);
    else selIdx = SEL_W'(int'(casLat) - 1);
    rdValid = pipeV[selIdx];
    rdData  = pipeD[selIdx];
  end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8,
  parameter int BEAT_W = 3,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic [1:0]        lenCode,
  input  logic              interleave,
  input  logic [1:0]        casLat,
  input  logic              writeSingle,
  input  logic [DATA_W-1:0] wrData,
  output logic              accActive,
  output logic [COL_W-1:0]  accCol,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  ctlStrobe_t        strobe;
  logic [BEAT_W-1:0] beatCur;

  sdram_seq_ctl #(.BEAT_W(BEAT_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .clkEn      (clkEn),
    .cmd        (cmd),
    .lenCode    (lenCode),
    .writeSingle(writeSingle),
    .strobe     (strobe),
    .beatCur    (beatCur)
  );

  sdram_seq_dp #(
    .BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .BEAT_W(BEAT_W), .MAX_CL(MAX_CL)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .beatCur   (beatCur),
    .bankIn    (bank),
    .colIn     (col),
    .lenCode   (lenCode),
    .interleave(interleave),
    .casLat    (casLat),
    .wrData    (wrData),
    .accCol    (accCol),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

  assign accActive = strobe.access;

endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BEAT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input ctlStrobe_t        strobe,
  input logic [BEAT_W-1:0] beatReg,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              accActive,
  input logic              writeSingle
);

  // R2: no access on an edge following a low enable sample
  a_r2_suppressed_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clkEn) |-> !accActive);

  // R3: outputs frozen across a suppressed edge
  a_r3_output_held: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clkEn) |=> ($stable(rdData) && $stable(rdValid)));

  // R4: beat counter frozen across a suppressed edge
  a_r4_beat_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clkEn) |=> $stable(beatReg));

  // R5: no continuation write beat while single-write mode is set
  a_r5_single_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.access && strobe.isWrite && !strobe.load) |-> !writeSingle);

endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.DATA_W(DATA_W), .BEAT_W(BEAT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clkEn      (clkEn),
  .strobe     (strobe),
  .beatReg    (u_ctl.beatR),
  .rdData     (rdData),
  .rdValid    (rdValid),
  .accActive  (accActive),
  .writeSingle(writeSingle)
);

// File: tb/sdram_burst_seq_bench.sv
module sdram_burst_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       clkEn;
  logic [1:0] cmd;
  logic [1:0] bank;
  logic [3:0] col;
  logic [1:0] lenCode;
  logic       interleave;
  logic [1:0] casLat;
  logic       writeSingle;
  logic [7:0] wrData;
  logic       accActive;
  logic [3:0] accCol;
  logic [7:0] rdData;
  logic       rdValid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] model [4][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_seq u_sdram_burst_seq (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .cmd(cmd), .bank(bank), .col(col),
    .lenCode(lenCode), .interleave(interleave), .casLat(casLat),
    .writeSingle(writeSingle), .wrData(wrData), .accActive(accActive),
    .accCol(accCol), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] colExp(input logic [3:0] start, input int beat,
                                        input int len, input bit ilv);
    logic [3:0] mask, low;
    mask = 4'(len - 1);
    low  = ilv ? (start ^ 4'(beat)) : (start + 4'(beat));
    return (start & ~mask) | (low & mask);
  endfunction

  task automatic nextEdge();
    @(posedge clk);
    #1;
  endtask

  task automatic doWrite(input logic [1:0] b, input logic [3:0] c, input logic [1:0] lc,
                         input bit ilv, input logic [7:0] base, input string req);
    int len = 1 << lc;
    int beats = writeSingle ? 1 : len;
    cmd = 2'd2; bank = b; col = c; lenCode = lc; interleave = ilv;
    for (int k = 0; k < len; k++) begin
      if (k > 0) cmd = 2'd0;
      wrData = base + 8'(k);
      #1;
      if (k < beats) begin
        chk({req, " write access"}, accActive, 1'b1);
        chk({req, " write column"}, accCol, colExp(c, k, len, ilv));
        model[b][colExp(c, k, len, ilv)] = base + 8'(k);
      end else begin
        chk("R5 single write stops", accActive, 1'b0);
      end
      nextEdge();
    end
    cmd = 2'd0;
  endtask

  task automatic doRead(input logic [1:0] b, input logic [3:0] c, input logic [1:0] lc,
                        input bit ilv, input logic [1:0] cl, input string req);
    int len = 1 << lc;
    int lat = (cl == 0) ? 1 : int'(cl);
    casLat = cl;
    cmd = 2'd1; bank = b; col = c; lenCode = lc; interleave = ilv;
    for (int n = 0; n < len + lat + 1; n++) begin
      int idx;
      nextEdge();
      cmd = 2'd0;
      idx = n - (lat - 1);
      if (idx >= 0 && idx < len) begin
        chk({req, " read valid"}, rdValid, 1'b1);
        chk({req, " read data"}, rdData, model[b][colExp(c, idx, len, ilv)]);
      end else begin
        chk({req, " read idle"}, rdValid, 1'b0);
      end
    end
  endtask

  task automatic testReset();
    rstN = 0; clkEn = 1; cmd = 0; bank = 0; col = 0; lenCode = 0;
    interleave = 0; casLat = 2'd2; writeSingle = 0; wrData = 0;
    repeat (3) nextEdge();
    rstN = 1;
    nextEdge();
    chk("R10 reset rdValid", rdValid, 1'b0);
    chk("R10 reset accActive", accActive, 1'b0);
  endtask

  task automatic testFill();
    doWrite(0, 0, 3, 0, 8'h10, "R1");
    doWrite(0, 8, 3, 0, 8'h18, "R1");
    doWrite(1, 3, 3, 1, 8'h40, "R7");
    doWrite(1, 12, 2, 0, 8'h60, "R6");
    doWrite(1, 9, 2, 1, 8'h70, "R7");
    doWrite(2, 0, 3, 0, 8'h80, "R1");
    doWrite(2, 8, 3, 0, 8'h88, "R1");
    doWrite(3, 0, 3, 0, 8'hC0, "R1");
    doWrite(3, 8, 3, 0, 8'hC8, "R1");
  endtask

  task automatic testReads();
    doRead(0, 5, 2, 0, 2'd2, "R7 seq");
    doRead(0, 5, 3, 1, 2'd3, "R7 ilv");
    doRead(1, 6, 1, 0, 2'd1, "R8 cl1");
    doRead(2, 7, 0, 0, 2'd2, "R6 len1");
    doRead(0, 14, 2, 0, 2'd0, "R8 cl0");
    doRead(1, 0, 3, 0, 2'd3, "R6 len8");
  endtask

  task automatic testSingleWrite();
    writeSingle = 1;
    doWrite(2, 5, 2, 0, 8'hA5, "R5");
    doRead(2, 4, 2, 0, 2'd2, "R5 read keeps length");
    writeSingle = 0;
  endtask

  task automatic testSuspendWrite();
    cmd = 2'd2; bank = 3; col = 0; lenCode = 2; interleave = 0; wrData = 8'hD0;
    nextEdge();
    cmd = 2'd0; wrData = 8'hD1; clkEn = 0;
    #1 chk("R4 beat1 before suspend", accCol, 4'd1);
    nextEdge();
    cmd = 2'd2; col = 8; wrData = 8'hEE; clkEn = 1;
    #1 chk("R2 suppressed edge idle", accActive, 1'b0);
    nextEdge();
    cmd = 2'd0; col = 0; wrData = 8'hD2;
    #1 chk("R4 resumes at beat2", accCol, 4'd2);
    chk("R4 resumes active", accActive, 1'b1);
    nextEdge();
    wrData = 8'hD3;
    nextEdge();
    model[3][0] = 8'hD0; model[3][1] = 8'hD1;
    model[3][2] = 8'hD2; model[3][3] = 8'hD3;
    doRead(3, 0, 2, 0, 2'd2, "R4 suspended write");
    doRead(3, 8, 0, 0, 2'd1, "R2 ignored command");
  endtask

  task automatic testSuspendRead();
    casLat = 2'd2;
    cmd = 2'd1; bank = 0; col = 0; lenCode = 2; interleave = 0;
    nextEdge();
    cmd = 2'd0; clkEn = 0;
    chk("R8 no data yet", rdValid, 1'b0);
    nextEdge();
    chk("R3 word0", rdData, model[0][0]);
    clkEn = 1;
    nextEdge();
    chk("R3 held valid", rdValid, 1'b1);
    chk("R3 held data", rdData, model[0][0]);
    nextEdge();
    chk("R4 word1 after resume", rdData, model[0][1]);
    nextEdge();
    chk("R4 word2", rdData, model[0][2]);
    nextEdge();
    chk("R4 word3", rdData, model[0][3]);
    nextEdge();
    chk("R4 burst ends", rdValid, 1'b0);
  endtask

  task automatic testTruncate();
    casLat = 2'd2;
    cmd = 2'd1; bank = 0; col = 0; lenCode = 3; interleave = 0;
    nextEdge();
    cmd = 2'd0;
    nextEdge();
    chk("R9 old word0", rdData, model[0][0]);
    cmd = 2'd1; bank = 1; col = 4; lenCode = 2;
    nextEdge();
    cmd = 2'd0;
    chk("R9 old word1", rdData, model[0][1]);
    for (int k = 0; k < 4; k++) begin
      nextEdge();
      chk("R9 new burst valid", rdValid, 1'b1);
      chk("R9 new burst data", rdData, model[1][4 + k]);
    end
    nextEdge();
    chk("R9 no stale beats", rdValid, 1'b0);
  endtask

  initial begin
    testReset();
    testFill();
    testReads();
    testSingleWrite();
    testSuspendWrite();
    testSuspendRead();
    testTruncate();
    repeat (3) nextEdge();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule